// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Steering Unit

This combinational unit sits between a processor core and a word-wide data memory that has one write enable per byte. The memory sees only a word index, never the two low byte-offset bits. On a store, the unit copies the register data into every lane the access could use. It then raises only the write-enable bits of the lanes that the access size and the byte offset actually select. On a load, it picks the addressed byte or halfword out of the returned word and sign-extends it to the full width. A word load is returned unchanged.

The access size is taken from the instruction's three-bit size field: 0 is a byte, 1 is a halfword and 2 is a word. Separate load and store strobes say which kind of access is in progress. An access that would cross its natural alignment is not split or emulated. Such an access writes nothing and loads zero. The same holds for any size code above 2. Only the low 16 bits of the byte address are brought to the unit.

Top module: `lsu_lane_align`

## Requirements
- R1: While `storeStrobe` is low, `memWriteMask` is 4'b0000 whatever the other inputs are.
- R2: A byte store (size code 0) sets only mask bit `byteAddr[1:0]`, where bit 3 is the most significant byte. It drives `storeData[7:0]` onto all four byte lanes of `memWriteData`.
- R3: A halfword store (size code 1) with `byteAddr[0]`=0 gives mask 4'b0011 when `byteAddr[1]`=0 and 4'b1100 when `byteAddr[1]`=1. It drives `storeData[15:0]` onto both halves of `memWriteData`.
- R4: A word store (size code 2) with `byteAddr[1:0]`=0 gives mask 4'b1111 and drives `storeData` unchanged.
- R5: Some accesses are misaligned or invalid: a halfword with `byteAddr[0]`=1, a word with `byteAddr[1:0]`≠0, or any size code from 3 to 7. For these the mask is 4'b0000 and `loadResult` is zero.
- R6: A byte load returns bits [8k+7:8k] of `memReadWord` sign-extended to 32 bits, where k=`byteAddr[1:0]`.
- R7: A halfword load returns bits [16h+15:16h] of `memReadWord` sign-extended to 32 bits, where h=`byteAddr[1]`.
- R8: A word load returns `memReadWord` unchanged.
- R9: While `loadStrobe` is low, `loadResult` is zero.
- R10: `memWordAddr` equals `byteAddr[15:2]` for every access, so byte address 0x1007 selects word index 0x401.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byteAddr | input | 16 | Low bits of the effective byte address |
| sizeCode | input | 3 | Access size field: 0 byte, 1 halfword, 2 word |
| loadStrobe | input | 1 | A load is in progress |
| storeStrobe | input | 1 | A store is in progress |
| storeData | input | 32 | Register value to store |
| memReadWord | input | 32 | Word returned by memory for `memWordAddr` |
| memWordAddr | output | 14 | Word index sent to memory |
| memWriteData | output | 32 | Lane-replicated store data |
| memWriteMask | output | 4 | Per-byte write enables |
| loadResult | output | 32 | Extracted and sign-extended load value |

## Verification
The bench stores a byte to each of the four lanes and a halfword to both halves. A design with a reversed lane order or a stuck offset bit would enable the wrong byte, so these stores expose it. It loads bytes and halfwords whose top bit is set and others whose top bit is clear. A design that zero-extends, or that takes the sign from the wrong bit, returns a wrong upper part. Misaligned halfwords, misaligned words and size code 3 are also driven. A design that emulated or partly performed them would show a nonzero mask or a nonzero load value. Address 0x1007 checks that the offset bits are dropped from the word index.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2
  } accessSize_e;

  // strobes from control to datapath; a select is only raised for a legal aligned access
  typedef struct packed {
    logic selByte;
    logic selHalf;
    logic selWord;
    logic doWrite;
    logic doLoad;
  } laneCtrl_t;
endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [2:0]       sizeCode,
  input  logic [OFF_W-1:0] offset,
  input  logic             loadStrobe,
  input  logic             storeStrobe,
  output laneCtrl_t        ctrl
);
  logic halfAligned;
  logic wordAligned;

  assign halfAligned = (offset[0] == 1'b0);
  assign wordAligned = (offset == '0);

  always_comb begin
    ctrl = '0;
    unique case (sizeCode)
      SZ_BYTE: ctrl.selByte = 1'b1;
      SZ_HALF: ctrl.selHalf = halfAligned;
      SZ_WORD: ctrl.selWord = wordAligned;
      default: ;
    endcase
    ctrl.doWrite = storeStrobe;
    ctrl.doLoad  = loadStrobe;
  end
endmodule

// File: rtl/lsu_lane_dp.sv
module lsu_lane_dp
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  laneCtrl_t         ctrl,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readWord,
  output logic [DATA_W-1:0] writeData,
  output logic [LANES-1:0]  writeMask,
  output logic [DATA_W-1:0] loadResult
);
  localparam int HALF_W = 16;

  logic anySel;
  assign anySel = ctrl.selByte | ctrl.selHalf | ctrl.selWord;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneHit;
    assign laneHit = (ctrl.selByte && offset == OFF_W'(i)) ||
                     (ctrl.selHalf && offset[OFF_W-1:1] == (OFF_W-1)'(i / 2)) ||
                     ctrl.selWord;
    assign writeMask[i] = ctrl.doWrite & laneHit;

    always_comb begin
      if (ctrl.selByte)      writeData[8*i +: 8] = storeData[7:0];
      else if (ctrl.selHalf) writeData[8*i +: 8] = storeData[8*(i%2) +: 8];
      else                   writeData[8*i +: 8] = storeData[8*i +: 8];
    end
  end

  logic [7:0]        pickedByte;
  logic [HALF_W-1:0] pickedHalf;

  assign pickedByte = readWord[{offset, 3'b000} +: 8];
  assign pickedHalf = readWord[{offset[OFF_W-1:1], 4'b0000} +: HALF_W];

  always_comb begin
    loadResult = '0;
    if (ctrl.doLoad && anySel) begin
      if (ctrl.selByte)      loadResult = {{(DATA_W-8){pickedByte[7]}}, pickedByte};
      else if (ctrl.selHalf) loadResult = {{(DATA_W-HALF_W){pickedHalf[HALF_W-1]}}, pickedHalf};
      else                   loadResult = readWord;
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [MEM_AW-1:0]       byteAddr,
  input  logic [2:0]              sizeCode,
  input  logic                    loadStrobe,
  input  logic                    storeStrobe,
  input  logic [DATA_W-1:0]       storeData,
  input  logic [DATA_W-1:0]       memReadWord,
  output logic [MEM_AW-OFF_W-1:0] memWordAddr,
  output logic [DATA_W-1:0]       memWriteData,
  output logic [LANES-1:0]        memWriteMask,
  output logic [DATA_W-1:0]       loadResult
);
  laneCtrl_t        ctrl;
  logic [OFF_W-1:0] offset;

  assign offset      = byteAddr[OFF_W-1:0];
  assign memWordAddr = byteAddr[MEM_AW-1:OFF_W];

  lsu_lane_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .sizeCode    (sizeCode),
    .offset      (offset),
    .loadStrobe  (loadStrobe),
    .storeStrobe (storeStrobe),
    .ctrl        (ctrl)
  );

  lsu_lane_dp #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_dp (
    .ctrl       (ctrl),
    .offset     (offset),
    .storeData  (storeData),
    .readWord   (memReadWord),
    .writeData  (memWriteData),
    .writeMask  (memWriteMask),
    .loadResult (loadResult)
  );
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk (
  input logic [15:0] byteAddr,
  input logic [2:0]  sizeCode,
  input logic        loadStrobe,
  input logic        storeStrobe,
  input logic [31:0] storeData,
  input logic [31:0] memReadWord,
  input logic [13:0] memWordAddr,
  input logic [31:0] memWriteData,
  input logic [3:0]  memWriteMask,
  input logic [31:0] loadResult
);
  logic known;
  logic badAccess;

  assign known = !$isunknown({byteAddr, sizeCode, loadStrobe, storeStrobe,
                              storeData, memReadWord});
  assign badAccess = (sizeCode > 3'd2) ||
                     (sizeCode == 3'd1 && byteAddr[0]) ||
                     (sizeCode == 3'd2 && byteAddr[1:0] != 2'b00);

  always_comb begin
    if (known) begin
      // R1
      no_store_no_mask_chk: assert (storeStrobe || memWriteMask == 4'b0000)
        else $error("mask raised without store");
      // R2
      byte_mask_onehot_chk: assert (!(storeStrobe && sizeCode == 3'd0) ||
                                    ($onehot0(memWriteMask) && memWriteMask != 4'b0000 &&
                                     memWriteData[31:24] == storeData[7:0]))
        else $error("byte store lane wrong");
      // R4
      mask_shape_chk: assert ($countones(memWriteMask) != 3)
        else $error("three lanes enabled");
      // R5
      bad_access_quiet_chk: assert (!badAccess || (memWriteMask == 4'b0000 && loadResult == 32'h0))
        else $error("misaligned access acted");
      // R6
      byte_sext_chk: assert (!(loadStrobe && sizeCode == 3'd0) ||
                             loadResult[31:8] == {24{loadResult[7]}})
        else $error("byte load not sign-extended");
      // R8
      word_load_chk: assert (!(loadStrobe && sizeCode == 3'd2 && byteAddr[1:0] == 2'b00) ||
                             loadResult == memReadWord)
        else $error("word load altered");
      // R9
      no_load_zero_chk: assert (loadStrobe || loadResult == 32'h0)
        else $error("load result without load");
      // R10
      word_index_chk: assert (memWordAddr == byteAddr[15:2])
        else $error("word index wrong");
    end
  end
endmodule

bind lsu_lane_align lsu_lane_chk u_chk (
  .byteAddr     (byteAddr),
  .sizeCode     (sizeCode),
  .loadStrobe   (loadStrobe),
  .storeStrobe  (storeStrobe),
  .storeData    (storeData),
  .memReadWord  (memReadWord),
  .memWordAddr  (memWordAddr),
  .memWriteData (memWriteData),
  .memWriteMask (memWriteMask),
  .loadResult   (loadResult)
);

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] byteAddr = '0;
  logic [2:0]  sizeCode = '0;
  logic        loadStrobe = 1'b0;
  logic        storeStrobe = 1'b0;
  logic [31:0] storeData = '0;
  logic [31:0] memReadWord = '0;
  logic [13:0] memWordAddr;
  logic [31:0] memWriteData;
  logic [3:0]  memWriteMask;
  logic [31:0] loadResult;

  lsu_lane_align uut (
    .byteAddr(byteAddr), .sizeCode(sizeCode), .loadStrobe(loadStrobe),
    .storeStrobe(storeStrobe), .storeData(storeData), .memReadWord(memReadWord),
    .memWordAddr(memWordAddr), .memWriteData(memWriteData),
    .memWriteMask(memWriteMask), .loadResult(loadResult)
  );

  typedef struct {
    int          req;
    logic [3:0]  mask;
    logic [31:0] wdata;
    logic [31:0] load;
    logic [13:0] widx;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  function automatic logic legal(input logic [15:0] a, input logic [2:0] f);
    case (f)
      3'd0: return 1'b1;
      3'd1: return a[0] == 1'b0;
      3'd2: return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input int req, input logic [15:0] a, input logic [2:0] f,
                       input logic ld, input logic st, input logic [31:0] d,
                       input logic [31:0] w);
    item_t it;
    logic [7:0]  b;
    logic [15:0] h;
    @(posedge clk);
    byteAddr = a; sizeCode = f; loadStrobe = ld; storeStrobe = st;
    storeData = d; memReadWord = w;
    it.req = req;
    it.widx = a >> 2;
    it.mask = 4'b0000;
    if (st && legal(a, f)) begin
      if (f == 3'd0)      it.mask = 4'b0001 << a[1:0];
      else if (f == 3'd1) it.mask = a[1] ? 4'b1100 : 4'b0011;
      else                it.mask = 4'b1111;
    end
    if (f == 3'd0)      it.wdata = {d[7:0], d[7:0], d[7:0], d[7:0]};
    else if (f == 3'd1) it.wdata = {d[15:0], d[15:0]};
    else                it.wdata = d;
    it.load = 32'h0;
    if (ld && legal(a, f)) begin
      case (a[1:0])
        2'd0: b = w[7:0];
        2'd1: b = w[15:8];
        2'd2: b = w[23:16];
        default: b = w[31:24];
      endcase
      h = a[1] ? w[31:16] : w[15:0];
      if (f == 3'd0)      it.load = {{24{b[7]}}, b};
      else if (f == 3'd1) it.load = {{16{h[15]}}, h};
      else                it.load = w;
    end
    expQ.push_back(it);
  endtask

  task automatic cmp(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: results settle after the posedge drive, compared at the following negedge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        cmp(it.req, "mask", {28'h0, memWriteMask}, {28'h0, it.mask});
        if (it.mask != 4'b0000) cmp(it.req, "wdata", memWriteData, it.wdata);
        cmp(it.req, "load", loadResult, it.load);
        cmp(10, "widx", {18'h0, memWordAddr}, {18'h0, it.widx});  // R10
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 R9: idle state after reset
    drive(1, 16'h0000, 3'd0, 1'b0, 1'b0, 32'h0, 32'h0);
    // R2: byte store to every lane
    for (int k = 0; k < 4; k++) drive(2, 16'h2000 + 16'(k), 3'd0, 1'b0, 1'b1, 32'hDEAD_BE5A, 32'h0);
    // R3: halfword stores, both halves
    drive(3, 16'h2000, 3'd1, 1'b0, 1'b1, 32'h1234_ABCD, 32'h0);
    drive(3, 16'h2002, 3'd1, 1'b0, 1'b1, 32'h1234_ABCD, 32'h0);
    // R4: word store
    drive(4, 16'h2004, 3'd2, 1'b0, 1'b1, 32'hCAFE_F00D, 32'h0);
    // R1: valid store fields but store strobe low
    drive(1, 16'h2004, 3'd2, 1'b0, 1'b0, 32'hCAFE_F00D, 32'h0);
    // R5: misaligned halfword, misaligned word, size code 3 (store and load)
    drive(5, 16'h2001, 3'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0);
    drive(5, 16'h2002, 3'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0);
    drive(5, 16'h2000, 3'd3, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0);
    drive(5, 16'h2003, 3'd1, 1'b1, 1'b0, 32'h0, 32'h8081_8283);
    drive(5, 16'h2001, 3'd2, 1'b1, 1'b0, 32'h0, 32'h8081_8283);
    drive(5, 16'h2000, 3'd3, 1'b1, 1'b0, 32'h0, 32'h8081_8283);
    // R6: byte loads, negative and positive lanes
    for (int k = 0; k < 4; k++) drive(6, 16'h3000 + 16'(k), 3'd0, 1'b1, 1'b0, 32'h0, 32'h7F80_017E);
    for (int k = 0; k < 4; k++) drive(6, 16'h3000 + 16'(k), 3'd0, 1'b1, 1'b0, 32'h0, 32'h81FF_00C3);
    // R7: halfword loads
    drive(7, 16'h3000, 3'd1, 1'b1, 1'b0, 32'h0, 32'h7FFF_8001);
    drive(7, 16'h3002, 3'd1, 1'b1, 1'b0, 32'h0, 32'h7FFF_8001);
    drive(7, 16'h3002, 3'd1, 1'b1, 1'b0, 32'h0, 32'h9ABC_1234);
    // R8: word load
    drive(8, 16'h3004, 3'd2, 1'b1, 1'b0, 32'h0, 32'hF00D_1234);
    // R9: read word present, load strobe low
    drive(9, 16'h3001, 3'd0, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF);
    // R10: offset bits dropped from the word index
    drive(10, 16'h1007, 3'd0, 1'b1, 1'b0, 32'h0, 32'h1122_3344);
    drive(10, 16'hFFFF, 3'd0, 1'b0, 1'b1, 32'h0000_00A5, 32'h0);
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule